// File: doc/BRIEF.md
# Configurable LUT logic cluster

This block is a cluster of ten identical logic cells that share one set of control lines: clock enable, synchronous clear, synchronous load and add/subtract. Each cell has a 4-input lookup table, one flip-flop and an arithmetic path. A static configuration word for each cell sets the table contents and several switches. The switches choose arithmetic or table mode, registered or combinational output, shift-chain capture, register feedback into the table, and table chaining from the previous cell.

In arithmetic mode the ten cells form one 10-bit adder/subtractor. Every cell computes two carry-outs, one for each possible incoming carry, and the real carry picks between them as it travels up the cluster. Subtraction is selected at run time by inverting the data1 operand. With the subtract control high and carry-in 1, the cluster returns data2 minus data1.

The cells also link to their neighbours without using the table. A register chain turns the ten flip-flops into a shift register. A table chain feeds each cell's table result into the next cell's fourth input. All pins are plain level signals. Values present in a cycle are used in that cycle, so the block has no valid/ready handshake and no back-pressure.

Top module: `logic_cluster`

## Requirements
- R1: In table mode, a cell's combinational result is `mask[{i4,i3,d2,d1}]`. Here i3 is d3 and i4 is d4 unless R10 or R9 substitutes them. With out_reg=0 this result appears on `y` in the same cycle.
- R2: The per-cell configuration word is 21 bits, and cell k sits at `cfg[21k+20:21k]`. Within that word: bits 20:5 are the table mask, bit 4 is arith, bit 3 is out_reg, bit 2 is shift_en, bit 1 is fb_en and bit 0 is lchain_en.
- R3: In arithmetic mode, cell k's result is bit k of `d2 + (d1 ^ {10{addsub}}) + cin`. So addsub=0 with cin=0 adds, and addsub=1 with cin=1 gives d2 - d1.
- R4: Every cell contributes to the carry chain, whatever its mode. Bit 10 of the R3 sum is registered into `cout` at every clock edge, so `cout` follows the operands with one cycle of latency. Reset sets `cout` to 0.
- R5: When ena=1 and sclr=1, every register becomes 0 at the clock edge, even if sload is also 1.
- R6: When ena=1, sclr=0 and sload=1, each register loads its own d3 bit.
- R7: When ena=0, no register changes, whatever sclr, sload or the data inputs do.
- R8: With shift_en=1 and no clear or load, a register captures the register of the cell below it. Cell 0 captures `reg_chain_in`. `reg_chain_out` is the register of cell 9.
- R9: With lchain_en=1, the cell's fourth table input is the table result of the cell below it, or `lut_chain_in` for cell 0. `lut_chain_out` is the table result of cell 9.
- R10: With fb_en=1, the cell's third table input is its own register instead of d3.
- R11: With out_reg=1, `y` shows the register. With shift_en=0 and no clear or load, the register captures the cell's combinational result, which is the table result or the sum bit.
- R12: An asynchronous active-low reset clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 210 | Static configuration, 21 bits per cell |
| ena | input | 1 | Cluster clock enable |
| sclr | input | 1 | Cluster synchronous clear |
| sload | input | 1 | Cluster synchronous load (loads d3) |
| addsub | input | 1 | 1 inverts d1 in the arithmetic path |
| cin | input | 1 | Cluster carry-in |
| d1 | input | 10 | Data input 1 of each cell |
| d2 | input | 10 | Data input 2 of each cell |
| d3 | input | 10 | Data input 3 of each cell |
| d4 | input | 10 | Data input 4 of each cell |
| reg_chain_in | input | 1 | Shift-chain input of cell 0 |
| lut_chain_in | input | 1 | Table-chain input of cell 0 |
| y | output | 10 | Cell outputs |
| reg_q | output | 10 | Cell register values |
| reg_chain_out | output | 1 | Register of cell 9 |
| lut_chain_out | output | 1 | Table result of cell 9 |
| cout | output | 1 | Registered cluster carry-out |

## Verification
The cluster-wide clear and load can be raised in the same cycle, and either can also coincide with shift capture. The clock enable then decides whether any of them acts. The bench draws ena, sclr and sload independently every cycle, under both shift and normal capture. A behavioural model decides which control wins, and its register values are compared with `reg_q` and `y` after every edge. Directed cycles with both clear and load high confirm that clear takes priority.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef struct packed {
    logic [15:0] mask;
    logic        arith;
    logic        out_reg;
    logic        shift_en;
    logic        fb_en;
    logic        lchain_en;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lc_carry_sel.sv
module lc_carry_sel #(
  parameter int N = 10
) (
  input  logic         cin,
  input  logic [N-1:0] co_if0,
  input  logic [N-1:0] co_if1,
  output logic [N:0]   carry
);
  always_comb begin
    carry[0] = cin;
    for (int k = 0; k < N; k++) begin
      carry[k+1] = carry[k] ? co_if1[k] : co_if0[k];
    end
  end
endmodule

// File: rtl/lc_cell.sv
module lc_cell
  import lc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cell_cfg_t cfg,
  input  logic      ena,
  input  logic      sclr,
  input  logic      sload,
  input  logic      addsub,
  input  logic      d1,
  input  logic      d2,
  input  logic      d3,
  input  logic      d4,
  input  logic      carry_in,
  input  logic      reg_chain_i,
  input  logic      lut_chain_i,
  output logic      y,
  output logic      q,
  output logic      lut_o,
  output logic      co_if0,
  output logic      co_if1
);
  logic op_a, sum, in3, in4, res;

  // arithmetic path: operand a is d1 optionally inverted
  assign op_a   = d1 ^ addsub;
  assign co_if0 = op_a & d2;
  assign co_if1 = op_a | d2;
  assign sum    = op_a ^ d2 ^ carry_in;

  // table path with optional feedback and chaining
  assign in3   = cfg.fb_en ? q : d3;
  assign in4   = cfg.lchain_en ? lut_chain_i : d4;
  assign lut_o = cfg.mask[{in4, in3, d2, d1}];

  assign res = cfg.arith ? sum : lut_o;
  assign y   = cfg.out_reg ? q : res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (ena) begin
      if (sclr)              q <= 1'b0;
      else if (sload)        q <= d3;
      else if (cfg.shift_en) q <= reg_chain_i;
      else                   q <= res;
    end
  end
endmodule

// File: rtl/logic_cluster.sv
module logic_cluster
  import lc_pkg::*;
#(
  parameter int N       = 10,
  parameter bit COUT_RG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N*21-1:0]  cfg,
  input  logic             ena,
  input  logic             sclr,
  input  logic             sload,
  input  logic             addsub,
  input  logic             cin,
  input  logic [N-1:0]     d1,
  input  logic [N-1:0]     d2,
  input  logic [N-1:0]     d3,
  input  logic [N-1:0]     d4,
  input  logic             reg_chain_in,
  input  logic             lut_chain_in,
  output logic [N-1:0]     y,
  output logic [N-1:0]     reg_q,
  output logic             reg_chain_out,
  output logic             lut_chain_out,
  output logic             cout
);
  logic [N-1:0] c0, c1;
  logic [N:0]   carry;
  logic [N:0]   lch;
  logic [N:0]   rch;

  assign lch[0] = lut_chain_in;
  assign rch[0] = reg_chain_in;

  lc_carry_sel #(.N(N)) i_carry (
    .cin    (cin),
    .co_if0 (c0),
    .co_if1 (c1),
    .carry  (carry)
  );

  for (genvar k = 0; k < N; k++) begin : g_cell
    lc_cell i_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg         (cell_cfg_t'(cfg[k*CFG_W +: CFG_W])),
      .ena         (ena),
      .sclr        (sclr),
      .sload       (sload),
      .addsub      (addsub),
      .d1          (d1[k]),
      .d2          (d2[k]),
      .d3          (d3[k]),
      .d4          (d4[k]),
      .carry_in    (carry[k]),
      .reg_chain_i (rch[k]),
      .lut_chain_i (lch[k]),
      .y           (y[k]),
      .q           (reg_q[k]),
      .lut_o       (lch[k+1]),
      .co_if0      (c0[k]),
      .co_if1      (c1[k])
    );
    assign rch[k+1] = reg_q[k];
  end

  assign reg_chain_out = rch[N];
  assign lut_chain_out = lch[N];

  if (COUT_RG) begin : g_cout_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cout <= 1'b0;
      else        cout <= carry[N];
    end
  end else begin : g_cout_comb
    assign cout = carry[N];
  end
endmodule

// File: rtl/lc_checker.sv
module lc_checker
  import lc_pkg::*;
#(
  parameter int N = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N*21-1:0] cfg,
  input logic            ena,
  input logic            sclr,
  input logic            sload,
  input logic [N-1:0]    d3,
  input logic            reg_chain_in,
  input logic [N-1:0]    y,
  input logic [N-1:0]    reg_q
);
  logic [N-1:0] sh_m, osel_m;
  cell_cfg_t    tmp;

  always_comb begin
    sh_m   = '0;
    osel_m = '0;
    tmp    = '0;
    for (int k = 0; k < N; k++) begin
      tmp       = cell_cfg_t'(cfg[k*CFG_W +: CFG_W]);
      sh_m[k]   = tmp.shift_en;
      osel_m[k] = tmp.out_reg;
    end
  end

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ena && sclr) |=> (reg_q == '0));

  p_load_d3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ena && !sclr && sload) |=> (reg_q == $past(d3)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena) |=> $stable(reg_q));

  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ena && !sclr && !sload && (&sh_m)) |=>
      (reg_q == {$past(reg_q[N-2:0]), $past(reg_chain_in)}));

  p_outsel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (((y ^ reg_q) & osel_m) == '0));
endmodule

bind logic_cluster lc_checker #(.N(N)) i_lc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg          (cfg),
  .ena          (ena),
  .sclr         (sclr),
  .sload        (sload),
  .d3           (d3),
  .reg_chain_in (reg_chain_in),
  .y            (y),
  .reg_q        (reg_q)
);

// File: tb/test_logic_cluster.sv
module test_logic_cluster;
  import lc_pkg::*;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*21-1:0] cfg;
  logic ena = 1'b0, sclr = 1'b0, sload = 1'b0, addsub = 1'b0, cin = 1'b0;
  logic [N-1:0] d1 = '0, d2 = '0, d3 = '0, d4 = '0;
  logic reg_chain_in = 1'b0, lut_chain_in = 1'b0;
  logic [N-1:0] y, reg_q;
  logic reg_chain_out, lut_chain_out, cout;

  cell_cfg_t cfg_a [N];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [N-1:0] mq;
  logic         mcout;

  always #4 clk = ~clk;

  always_comb begin
    cfg = '0;
    for (int k = 0; k < N; k++) cfg[k*21 +: 21] = cfg_a[k];
  end

  logic_cluster i_logic_cluster (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .ena(ena), .sclr(sclr),
    .sload(sload), .addsub(addsub), .cin(cin), .d1(d1), .d2(d2),
    .d3(d3), .d4(d4), .reg_chain_in(reg_chain_in),
    .lut_chain_in(lut_chain_in), .y(y), .reg_q(reg_q),
    .reg_chain_out(reg_chain_out), .lut_chain_out(lut_chain_out),
    .cout(cout)
  );

  task automatic chk(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input bit ar, input bit orr, input bit sh,
                         input bit fb, input bit lc);
    for (int k = 0; k < N; k++) begin
      cfg_a[k].mask      = 16'($urandom);
      cfg_a[k].arith     = ar;
      cfg_a[k].out_reg   = orr;
      cfg_a[k].shift_en  = sh;
      cfg_a[k].fb_en     = fb;
      cfg_a[k].lchain_en = lc;
    end
  endtask

  task automatic rand_data();
    d1 = N'($urandom); d2 = N'($urandom);
    d3 = N'($urandom); d4 = N'($urandom);
    addsub = 1'($urandom); cin = 1'($urandom);
    reg_chain_in = 1'($urandom); lut_chain_in = 1'($urandom);
  endtask

  // one clock: compare at the falling edge, then advance the model
  task automatic cycle(input string tag);
    logic [N-1:0] lutv, resv, yexp, nq;
    logic [N:0]   s;
    logic         prev, i3, i4;
    @(negedge clk);
    s = {1'b0, d2} + {1'b0, d1 ^ {N{addsub}}} + (N+1)'(cin);
    prev = lut_chain_in;
    for (int k = 0; k < N; k++) begin
      i3 = cfg_a[k].fb_en ? mq[k] : d3[k];           // R10
      i4 = cfg_a[k].lchain_en ? prev : d4[k];        // R9
      lutv[k] = cfg_a[k].mask[{i4, i3, d2[k], d1[k]}]; // R1
      prev = lutv[k];
      resv[k] = cfg_a[k].arith ? s[k] : lutv[k];     // R3
      yexp[k] = cfg_a[k].out_reg ? mq[k] : resv[k];  // R11
    end
    chk(tag, "y", y, yexp);
    chk(tag, "reg_q", reg_q, mq);
    chk(tag, "cout", N'(cout), N'(mcout));
    chk(tag, "chain_outs", N'({reg_chain_out, lut_chain_out}),
        N'({mq[N-1], lutv[N-1]}));
    for (int k = 0; k < N; k++) begin
      if (!ena)                   nq[k] = mq[k];
      else if (sclr)              nq[k] = 1'b0;
      else if (sload)             nq[k] = d3[k];
      else if (cfg_a[k].shift_en) nq[k] = (k == 0) ? reg_chain_in : mq[k-1];
      else                        nq[k] = resv[k];
    end
    @(posedge clk);
    #1;
    mq = nq;
    mcout = s[N];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mq = '0; mcout = 1'b0;
    set_cfg(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "reg_q in reset", reg_q, '0);
    chk("R12", "cout in reset", N'(cout), '0);
    rst_n = 1'b1;
    ena = 1'b1;
    // R1 R2: table mode, random masks and data
    for (int n = 0; n < 40; n++) begin
      if (n % 8 == 0) set_cfg(0, 0, 0, 0, 0);
      rand_data(); cycle("R1");
    end
    // R11: registered output
    set_cfg(0, 1, 0, 0, 0);
    for (int n = 0; n < 20; n++) begin rand_data(); cycle("R11"); end
    // R3 R4: arithmetic, random operands
    set_cfg(1, 0, 0, 0, 0);
    for (int n = 0; n < 200; n++) begin rand_data(); cycle("R3"); end
    // R4 corners: full carry ripple and exact subtraction
    d2 = '1; d1 = 10'd1; addsub = 0; cin = 0; cycle("R4");
    d2 = '1; d1 = '0; addsub = 0; cin = 1; cycle("R4");
    d2 = 10'd5; d1 = 10'd5; addsub = 1; cin = 1; cycle("R3");
    d2 = 10'd4; d1 = 10'd5; addsub = 1; cin = 1; cycle("R3");
    cycle("R4");
    // R5 R6 R7: controls drawn every cycle, normal and shift capture
    for (int n = 0; n < 120; n++) begin
      if (n == 60) set_cfg(0, 0, 1, 0, 0);
      rand_data();
      ena = 1'($urandom); sclr = 1'($urandom); sload = 1'($urandom);
      cycle("R5");
    end
    // directed: clear and load together, load alone, enable low
    set_cfg(0, 0, 0, 0, 0);
    rand_data(); ena = 1; sclr = 0; sload = 1; cycle("R6");
    ena = 1; sclr = 1; sload = 1; cycle("R5");
    d3 = '1; ena = 0; sclr = 0; sload = 1; cycle("R7");
    ena = 1; sclr = 0; sload = 1; cycle("R6");
    ena = 0; sclr = 1; sload = 0; cycle("R7");
    cycle("R7");
    ena = 1; sclr = 0; sload = 0;
    // R8: shift chain
    set_cfg(0, 0, 1, 0, 0);
    for (int n = 0; n < 30; n++) begin rand_data(); cycle("R8"); end
    // R9: table chain
    set_cfg(0, 0, 0, 0, 1);
    for (int n = 0; n < 40; n++) begin
      if (n % 10 == 0) set_cfg(0, 0, 0, 0, 1);
      rand_data(); cycle("R9");
    end
    // R10: register feedback into the table
    for (int n = 0; n < 40; n++) begin
      if (n % 10 == 0) set_cfg(0, 0, 0, 1, 0);
      rand_data(); cycle("R10");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule